// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Generator

This block produces the card-side reply to a synchronous reset on a smart-card style serial memory. A fast system clock runs the logic; the card's reset pin and card clock pin arrive as ordinary asynchronous inputs. Both pins are synchronised and edge-detected in the system domain. A reset pulse that holds at least one card clock rising edge between its own rising and falling edges counts as a valid request. When such a pulse ends, the block drives a fixed 32-bit answer onto the serial data line. It sends one bit per card clock and then returns to standby.

A reset pulse arriving while the answer is being sent interrupts it. If that pulse holds a card clock edge, the answer starts over from its first bit. If it holds none, the transfer is abandoned silently. A nonvolatile write in progress (write-busy input) prevents a reset pulse from starting the answer. A power-fail input drops the block to standby at once.

The controller has three states. `ST_IDLE` is standby with the line released. `ST_ARMED` means a reset pulse is in progress. `ST_SEND` means answer bits are being driven. The transitions are:
- IDLE→ARMED on a reset rising edge.
- ARMED→SEND on a reset falling edge, when a card clock edge was seen and write-busy is low.
- ARMED→IDLE on a reset falling edge otherwise.
- SEND→ARMED on a reset rising edge.
- SEND→SEND on a card clock falling edge with bits left, which advances the bit index.
- SEND→IDLE on the card clock falling edge after the last bit.
- Any state→IDLE while power-fail is high.

Top module: `sync_atr_gen`

## Requirements
- R1: After system reset, `dat_oe_o` and `dat_o` are both 0.
- R2: A card reset pulse that contains a card clock rising edge, and ends while `wr_busy_i` is low, makes the block drive bit 0 of `RESP` with `dat_oe_o` high after the reset falling edge.
- R3: After the n-th card clock falling edge that follows the reset falling edge, bit n of `RESP` is driven, for n = 1 to 31. Bits go in ascending index order.
- R4: The card clock falling edge after bit 31 releases the line (`dat_oe_o` low), and further card clocks drive nothing.
- R5: `RESP` defaults to 32'h55AA4119, so the bytes leave in the order 0x19, 0x41, 0xAA, 0x55, each byte LSB first. Other parameter values are sent the same way.
- R6: A valid reset pulse (one containing a card clock rising edge) during a transfer restarts the answer at bit 0.
- R7: A reset pulse with no card clock rising edge inside it, whether during a transfer or from standby, leaves the line released. Later card clocks do not bring it back.
- R8: If `wr_busy_i` is high when the reset pulse ends, no answer starts and the line stays released.
- R9: One system-clock cycle with `pwr_fail_i` high releases the line by the next cycle and aborts the transfer. Later card clocks do not resume it.
- R10: The line is released while the card reset pin is held high.
- R11: `dat_o` is 0 whenever `dat_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low system reset |
| card_clk_i | input | 1 | Card clock pin, asynchronous |
| card_rst_i | input | 1 | Card reset pin, asynchronous, active high |
| wr_busy_i | input | 1 | Nonvolatile write in progress |
| pwr_fail_i | input | 1 | Power failure, aborts the answer |
| dat_o | output | 1 | Serial answer bit |
| dat_oe_o | output | 1 | Data line drive enable |

## Verification
A card pin change reaches the outputs on the third system-clock edge after it. Two edges go to the synchroniser, and one goes to the edge detector feeding the state register. Power-fail acts on the very next edge because it is not synchronised. The bench holds each card pin level for eight system cycles and samples just after a system edge at the end of that hold, so every result has settled before it is read. A second instance with a different answer value receives the same stimulus, which shows that the parameter sets the bits sent.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } atr_state_e;

    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/atr_sync.sv
// Multi-stage synchroniser with registered edge detection per bit.
module atr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = atr_pkg::SYNC_STAGES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign rise_o[b] =  chain_q[STAGES-1] & ~prev_q;
        assign fall_o[b] = ~chain_q[STAGES-1] &  prev_q;
    end
endmodule

// File: rtl/atr_pulse_mon.sv
// Records whether a card clock rising edge fell inside the current reset pulse.
module atr_pulse_mon (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rst_rise_i,
    input  logic rst_fall_i,
    input  logic cclk_rise_i,
    output logic clk_seen_o
);
    logic in_pulse_q;
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            in_pulse_q <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            if (rst_rise_i) begin
                in_pulse_q <= 1'b1;
                seen_q     <= 1'b0;
            end else begin
                if (rst_fall_i) begin
                    in_pulse_q <= 1'b0;
                end
                if (in_pulse_q && cclk_rise_i) begin
                    seen_q <= 1'b1;
                end
            end
        end
    end

    assign clk_seen_o = seen_q;
endmodule

// File: rtl/atr_bit_ctr.sv
// Index of the answer bit currently on the line.
module atr_bit_ctr #(
    parameter int unsigned NBITS = 32,
    localparam int unsigned IDX_W = $clog2(NBITS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
        end else if (step_i && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/sync_atr_gen.sv
module sync_atr_gen #(
    parameter int unsigned       RESP_W = 32,
    parameter logic [RESP_W-1:0] RESP   = 32'h55AA4119
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic card_clk_i,
    input  logic card_rst_i,
    input  logic wr_busy_i,
    input  logic pwr_fail_i,
    output logic dat_o,
    output logic dat_oe_o
);
    import atr_pkg::*;

    localparam int unsigned IDX_W = $clog2(RESP_W);
    localparam int unsigned PIN_RST = 0;
    localparam int unsigned PIN_CLK = 1;

    logic [1:0]       pins;
    logic [1:0]       pin_rise;
    logic [1:0]       pin_fall;
    logic             rst_rise, rst_fall, cclk_rise, cclk_fall;
    logic             clk_seen;
    logic             ctr_load, ctr_step, ctr_last;
    logic [IDX_W-1:0] bit_idx;
    atr_state_e       state_q, state_d;

    assign pins = {card_clk_i, card_rst_i};

    atr_sync #(.WIDTH(2)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pins),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign rst_rise  = pin_rise[PIN_RST];
    assign rst_fall  = pin_fall[PIN_RST];
    assign cclk_rise = pin_rise[PIN_CLK];
    assign cclk_fall = pin_fall[PIN_CLK];

    atr_pulse_mon mon_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rst_rise_i  (rst_rise),
        .rst_fall_i  (rst_fall),
        .cclk_rise_i (cclk_rise),
        .clk_seen_o  (clk_seen)
    );

    atr_bit_ctr #(.NBITS(RESP_W)) ctr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (ctr_load),
        .step_i (ctr_step),
        .idx_o  (bit_idx),
        .last_o (ctr_last)
    );

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        if (pwr_fail_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rst_rise) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (rst_fall) begin
                        if (clk_seen && !wr_busy_i) begin
                            state_d  = ST_SEND;
                            ctr_load = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_SEND: begin
                    if (rst_rise) begin
                        state_d = ST_ARMED;
                    end else if (cclk_fall) begin
                        if (ctr_last) state_d = ST_IDLE;
                        else          ctr_step = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        dat_oe_o = 1'b0;
        dat_o    = 1'b0;
        unique case (state_q)
            ST_SEND: begin
                dat_oe_o = 1'b1;
                dat_o    = RESP[bit_idx];
            end
            ST_IDLE, ST_ARMED: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/sync_atr_gen_chk.sv
module sync_atr_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic card_rst_i,
    input logic wr_busy_i,
    input logic pwr_fail_i,
    input logic dat_o,
    input logic dat_oe_o
);
    a_r11_dat_low_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dat_oe_o |-> !dat_o);

    a_r9_pwr_fail_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_fail_i |=> !dat_oe_o);

    a_r8_busy_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dat_oe_o) |-> (!$past(wr_busy_i) && !$past(pwr_fail_i)));

    a_r10_released_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (card_rst_i && $past(card_rst_i) && $past(card_rst_i, 2) && $past(card_rst_i, 3))
        |-> !dat_oe_o);
endmodule

bind sync_atr_gen sync_atr_gen_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .card_rst_i (card_rst_i),
    .wr_busy_i  (wr_busy_i),
    .pwr_fail_i (pwr_fail_i),
    .dat_o      (dat_o),
    .dat_oe_o   (dat_oe_o)
);

// File: tb/sync_atr_gen_tb_top.sv
`timescale 1ns/1ps
module sync_atr_gen_tb_top;
    localparam logic [31:0] DEF_RESP = 32'h55AA4119;
    localparam logic [31:0] ALT_RESP = 32'hC3A50F96;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_clk = 1'b0, card_rst = 1'b0, wr_busy = 1'b0, pwr_fail = 1'b0;
    logic dat, dat_oe, dat2, dat2_oe;
    int   n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    sync_atr_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .card_clk_i(card_clk), .card_rst_i(card_rst),
        .wr_busy_i(wr_busy), .pwr_fail_i(pwr_fail), .dat_o(dat), .dat_oe_o(dat_oe)
    );

    sync_atr_gen #(.RESP_W(32), .RESP(ALT_RESP)) dut_alt_i (
        .clk_i(clk), .rst_ni(rst_n), .card_clk_i(card_clk), .card_rst_i(card_rst),
        .wr_busy_i(wr_busy), .pwr_fail_i(pwr_fail), .dat_o(dat2), .dat_oe_o(dat2_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic cclk_pulse();
        card_clk = 1'b1; wait_cyc(HOLD);
        card_clk = 1'b0; wait_cyc(HOLD);
    endtask

    // Reset pulse, optionally with a card clock pulse inside; checks R10 mid-pulse.
    task automatic rst_pulse(input bit with_clk);
        card_rst = 1'b1; wait_cyc(HOLD);
        chk("R10 line released in reset pulse", {31'd0, dat_oe}, 32'd0);
        if (with_clk) cclk_pulse();
        else          wait_cyc(2 * HOLD);
        card_rst = 1'b0; wait_cyc(HOLD);
    endtask

    // Collect bits 0..n-1; bit 0 is already on the line.
    task automatic read_bits(input int n, output logic [31:0] v, output logic [31:0] v2,
                             output int oe_ok);
        v = '0; v2 = '0; oe_ok = 1;
        for (int k = 0; k < n; k++) begin
            if (k > 0) cclk_pulse();
            v[k] = dat; v2[k] = dat2;
            if (dat_oe !== 1'b1 || dat2_oe !== 1'b1) oe_ok = 0;
        end
    endtask

    task automatic t_reset_state();
        chk("R1 oe after reset", {31'd0, dat_oe}, 32'd0);
        chk("R1 dat after reset", {31'd0, dat}, 32'd0);
    endtask

    task automatic t_full_answer();
        logic [31:0] v, v2; int ok;
        rst_pulse(1'b1);
        chk("R2 first bit driven", {31'd0, dat_oe}, 32'd1);
        read_bits(32, v, v2, ok);
        chk("R3 oe held through answer", ok, 1);
        chk("R5 default answer", v, DEF_RESP);
        chk("R5 R3 alternate answer", v2, ALT_RESP);
        cclk_pulse();
        chk("R4 released after last bit", {30'd0, dat_oe, dat2_oe}, 32'd0);
        chk("R11 dat low when released", {30'd0, dat, dat2}, 32'd0);
        cclk_pulse();
        chk("R4 stays released", {31'd0, dat_oe}, 32'd0);
    endtask

    task automatic t_restart();
        logic [31:0] v, v2; int ok;
        rst_pulse(1'b1);
        read_bits(10, v, v2, ok);
        chk("R3 partial prefix", v & 32'h3FF, DEF_RESP & 32'h3FF);
        rst_pulse(1'b1);
        read_bits(32, v, v2, ok);
        chk("R6 restart oe", ok, 1);
        chk("R6 restart from bit 0", v, DEF_RESP);
        cclk_pulse();
    endtask

    task automatic t_abort();
        logic [31:0] v, v2; int ok;
        rst_pulse(1'b1);
        read_bits(5, v, v2, ok);
        rst_pulse(1'b0);
        chk("R7 abort releases", {31'd0, dat_oe}, 32'd0);
        cclk_pulse(); cclk_pulse();
        chk("R7 no resume after abort", {31'd0, dat_oe}, 32'd0);
        rst_pulse(1'b0);
        chk("R7 clockless pulse from standby", {31'd0, dat_oe}, 32'd0);
    endtask

    task automatic t_busy();
        wr_busy = 1'b1;
        rst_pulse(1'b1);
        chk("R8 busy blocks start", {31'd0, dat_oe}, 32'd0);
        cclk_pulse();
        chk("R8 still released", {31'd0, dat_oe}, 32'd0);
        wr_busy = 1'b0;
    endtask

    task automatic t_pwr_fail();
        logic [31:0] v, v2; int ok;
        rst_pulse(1'b1);
        read_bits(3, v, v2, ok);
        chk("R9 sending before fail", ok, 1);
        pwr_fail = 1'b1; wait_cyc(1);
        pwr_fail = 1'b0;
        chk("R9 released after power fail", {31'd0, dat_oe}, 32'd0);
        cclk_pulse(); cclk_pulse();
        chk("R9 no resume after power fail", {31'd0, dat_oe}, 32'd0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset_state();
        t_full_answer();
        t_restart();
        t_abort();
        t_busy();
        t_pwr_fail();
        t_full_answer();
        finish_run();
    end

    initial begin
        wait_cyc(150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule